// File: doc/BRIEF.md
# Host Command Mailbox Register Unit

This unit is a small register mailbox that sits between a host and an agent on the device side. A host places parameters in argument words, posts a command code, waits for the device to answer in the same word, and then writes zero to finish the exchange. The host and the device each have their own simple register bus with a write strobe and a read strobe. Both buses reach the same set of words: the command/response word, a parameterised number of argument words, and an identity word that only the host may write.

The unit enforces the exchange instead of just storing it. A command is accepted only under four conditions: the mailbox is clear, the host holds the mailbox lock, the identity word is well formed, and the code lies in the defined command range. Any other non-zero host write to the command word is dropped and sets a sticky error flag. A device write counts as an answer only while a command is outstanding. The lock is a test-and-set word: a host read of it acquires it. If a host leaves the mailbox non-clear for longer than a programmable number of cycles, the unit presumes that host is dead. It then writes a timeout answer, frees the lock and pulses an interrupt.

Word addresses on both buses: 0 is the command/response word, 1 to N_ARGS are the arguments, N_ARGS+1 is the identity word and N_ARGS+2 is the lock. With the default N_ARGS of 3 these are addresses 0, 1-3, 4 and 5. Read data appears on the read-data port in the cycle after the read strobe and holds until the next read.

Top module: `host_mbox_unit`

## Requirements
- R1: After reset, every mailbox word reads 0, the lock is free, and stuck_irq and cmd_error are 0.
- R2: A host read of the lock address returns 1 and takes the lock if the lock was free, and returns 0 if it was held. A host write of 0 to the lock address frees it. A device read of the lock address returns the held flag without changing it. Read data appears one cycle after the read strobe.
- R3: Argument words are writable and readable from both buses. The host has priority when both sides write the same word in one cycle. The identity word is written only by the host; a device write to it leaves it unchanged.
- R4: The identity word is valid only when bits [31:16] equal 0xCAFE and bits [7:0] are below 8. Bits [15:8] are a free version field. A host command posted with an invalid identity word is rejected.
- R5: A host write of a non-zero value to the command word is accepted only if four conditions all hold. Bit 31 is set. Bits [30:0] are in 0x01..0x12 and not in 0x0B..0x0D. The word currently reads 0. The lock is held and the identity word is valid. Otherwise the word is unchanged and cmd_error is set.
- R6: A device write to the command word is taken as a response only if bit 31 is 0, the value is non-zero, and a command is outstanding (the word has bit 31 set). Any other device write to it is ignored.
- R7: A host write of 0 to the command word returns it to 0 from any state, without an error, and the next valid command is accepted.
- R8: If the command word stays non-clear for stuck_limit cycles without the device answering or the host clearing, it becomes 0x00000003, the lock is freed and stuck_irq is high for exactly one cycle. A device answer restarts that window. A stuck_limit of 0 disables the timeout.
- R9: cmd_error stays set until reset, through later accepted transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after host_rd |
| dev_wr | input | 1 | Device write strobe |
| dev_rd | input | 1 | Device read strobe |
| dev_addr | input | ADDR_W | Device word address |
| dev_wdata | input | 32 | Device write data |
| dev_rdata | output | 32 | Device read data, valid the cycle after dev_rd |
| stuck_limit | input | TMO_W | Cycles a non-clear mailbox may last; 0 disables |
| stuck_irq | output | 1 | One-cycle pulse when a stuck mailbox is reclaimed |
| cmd_error | output | 1 | Sticky flag for a dropped host command write |

## Verification
Several rules are checked by the assertions on every cycle. A command may appear in the word only if the lock was held and the identity word was valid in the cycle before. A drop of bit 31 to a non-zero value needs a device write or a timeout. The interrupt is a single-cycle pulse that comes with a freed lock and the timeout code, and the error flag never falls. The directed scenarios are what show that particular values are rejected: the unused code hole, codes past the end of the range, a function number of 8 and a wrong magic. They also show the exact cycle on which the timeout fires, that a limit of 0 never fires, the lock's test-and-set read values, and the host-only write rule for the identity word.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CMD_FLAG = 31;
    localparam logic [15:0] ID_MAGIC = 16'hCAFE;
    localparam logic [7:0]  FN_LIMIT = 8'd8;
    localparam logic [WORD_W-1:0] RSP_TIMEOUT = 32'h0000_0003;
    localparam logic [30:0] CODE_FIRST = 31'h01;
    localparam logic [30:0] CODE_LAST  = 31'h12;
    localparam logic [30:0] HOLE_FIRST = 31'h0B;
    localparam logic [30:0] HOLE_LAST  = 31'h0D;

    typedef enum logic [1:0] {
        MB_IDLE,
        MB_PENDING,
        MB_ANSWERED,
        MB_EXPIRED
    } mb_state_e;

    function automatic logic cmd_code_ok(input logic [WORD_W-1:0] w);
        logic in_range;
        logic in_hole;
        in_range = (w[30:0] >= CODE_FIRST) && (w[30:0] <= CODE_LAST);
        in_hole  = (w[30:0] >= HOLE_FIRST) && (w[30:0] <= HOLE_LAST);
        return w[CMD_FLAG] && in_range && !in_hole;
    endfunction

endpackage

// File: rtl/mbox_sig_check.sv
module mbox_sig_check
    import mbox_pkg::*;
(
    input  logic [15:0] magic_i,
    input  logic [7:0]  fn_i,
    output logic        valid_o
);
    always_comb begin
        valid_o = (magic_i == ID_MAGIC) && (fn_i < FN_LIMIT);
    end
endmodule

// File: rtl/mbox_lock.sv
module mbox_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic try_i,
    input  logic release_i,
    input  logic force_free_i,
    output logic grant_o,
    output logic held_o
);
    typedef struct packed {
        logic held;
    } lock_s;

    lock_s l_d, l_q;

    always_comb begin
        l_d     = l_q;
        grant_o = 1'b0;
        if (force_free_i) begin
            l_d.held = 1'b0;
        end else if (try_i && !l_q.held) begin
            l_d.held = 1'b1;
            grant_o  = 1'b1;
        end else if (release_i) begin
            l_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign held_o = l_q.held;
endmodule

// File: rtl/mbox_stuck_timer.sv
module mbox_stuck_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s t_d, t_q;

    always_comb begin
        t_d      = t_q;
        expire_o = run_i && !restart_i && (limit_i != '0)
                   && (t_q.cnt == limit_i - CNT_W'(1));
        if (!run_i || restart_i) t_d.cnt = '0;
        else                     t_d.cnt = t_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/mbox_arg_bank.sv
module mbox_arg_bank #(
    parameter int unsigned N_ARGS = 3,
    parameter int unsigned WORD_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_ARGS-1:0]             host_we_i,
    input  logic [N_ARGS-1:0]             dev_we_i,
    input  logic [WORD_W-1:0]             host_wdata_i,
    input  logic [WORD_W-1:0]             dev_wdata_i,
    output logic [N_ARGS-1:0][WORD_W-1:0] args_o
);
    logic [N_ARGS-1:0][WORD_W-1:0] args_d, args_q;

    for (genvar g = 0; g < N_ARGS; g++) begin : g_arg
        always_comb begin
            if (host_we_i[g])     args_d[g] = host_wdata_i;
            else if (dev_we_i[g]) args_d[g] = dev_wdata_i;
            else                  args_d[g] = args_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) args_q <= '0;
        else        args_q <= args_d;
    end

    assign args_o = args_q;
endmodule

// File: rtl/host_mbox_unit.sv
module host_mbox_unit
    import mbox_pkg::*;
#(
    parameter int unsigned N_ARGS = 3,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              dev_wr,
    input  logic              dev_rd,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [31:0]       dev_wdata,
    output logic [31:0]       dev_rdata,
    input  logic [TMO_W-1:0]  stuck_limit,
    output logic              stuck_irq,
    output logic              cmd_error
);
    localparam logic [ADDR_W-1:0] A_CMD  = '0;
    localparam logic [ADDR_W-1:0] A_SIG  = ADDR_W'(N_ARGS + 1);
    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(N_ARGS + 2);

    typedef struct packed {
        mb_state_e         st;
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] sig;
        logic [WORD_W-1:0] hrd;
        logic [WORD_W-1:0] drd;
        logic              irq;
        logic              err;
    } mb_s;

    mb_s r_d, r_q;

    logic [N_ARGS-1:0][WORD_W-1:0] args;
    logic [N_ARGS-1:0] h_arg_we, d_arg_we;
    logic sig_valid, lock_held, lock_grant;
    logic h_cmd_wr, d_cmd_wr, h_clear, cmd_accept, cmd_reject, rsp_accept;
    logic expire, stuck_fire, lock_try, lock_rel, tmr_run;
    logic [WORD_W-1:0] cmd_word;

    for (genvar g = 0; g < N_ARGS; g++) begin : g_we
        assign h_arg_we[g] = host_wr && (host_addr == ADDR_W'(g + 1));
        assign d_arg_we[g] = dev_wr  && (dev_addr  == ADDR_W'(g + 1));
    end

    mbox_arg_bank #(.N_ARGS(N_ARGS), .WORD_W(WORD_W)) u_args (
        .clk(clk), .rst_n(rst_n),
        .host_we_i(h_arg_we), .dev_we_i(d_arg_we),
        .host_wdata_i(host_wdata), .dev_wdata_i(dev_wdata),
        .args_o(args)
    );

    mbox_sig_check u_sig (
        .magic_i(r_q.sig[31:16]), .fn_i(r_q.sig[7:0]), .valid_o(sig_valid)
    );

    assign lock_try = host_rd && (host_addr == A_LOCK);
    assign lock_rel = host_wr && (host_addr == A_LOCK) && (host_wdata == '0);

    mbox_lock u_lock (
        .clk(clk), .rst_n(rst_n),
        .try_i(lock_try), .release_i(lock_rel), .force_free_i(stuck_fire),
        .grant_o(lock_grant), .held_o(lock_held)
    );

    assign tmr_run = (r_q.st == MB_PENDING) || (r_q.st == MB_ANSWERED);

    mbox_stuck_timer #(.CNT_W(TMO_W)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .run_i(tmr_run), .restart_i(rsp_accept || h_clear),
        .limit_i(stuck_limit), .expire_o(expire)
    );

    always_comb begin
        h_cmd_wr   = host_wr && (host_addr == A_CMD);
        d_cmd_wr   = dev_wr  && (dev_addr  == A_CMD);
        h_clear    = h_cmd_wr && (host_wdata == '0);
        cmd_accept = h_cmd_wr && !h_clear && cmd_code_ok(host_wdata)
                     && (r_q.cmd == '0) && lock_held && sig_valid;
        cmd_reject = h_cmd_wr && !h_clear && !cmd_accept;
        rsp_accept = d_cmd_wr && !h_cmd_wr && !dev_wdata[CMD_FLAG]
                     && (dev_wdata != '0) && (r_q.st == MB_PENDING);
        stuck_fire = expire && !h_clear;
    end

    function automatic logic [WORD_W-1:0] word_at(
        input logic [ADDR_W-1:0]             a,
        input logic [WORD_W-1:0]             c,
        input logic [WORD_W-1:0]             s,
        input logic [N_ARGS-1:0][WORD_W-1:0] ar,
        input logic                          lk);
        logic [WORD_W-1:0] v;
        v = '0;
        if (a == A_CMD)       v = c;
        else if (a == A_SIG)  v = s;
        else if (a == A_LOCK) v = {{(WORD_W-1){1'b0}}, lk};
        else begin
            for (int i = 0; i < N_ARGS; i++) begin
                if (a == ADDR_W'(i + 1)) v = ar[i];
            end
        end
        return v;
    endfunction

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        if (h_clear) begin
            r_d.cmd = '0;
            r_d.st  = MB_IDLE;
        end else if (stuck_fire) begin
            r_d.cmd = RSP_TIMEOUT;
            r_d.st  = MB_EXPIRED;
            r_d.irq = 1'b1;
        end else if (rsp_accept) begin
            r_d.cmd = dev_wdata;
            r_d.st  = MB_ANSWERED;
        end else if (cmd_accept) begin
            r_d.cmd = host_wdata;
            r_d.st  = MB_PENDING;
        end
        if (cmd_reject) r_d.err = 1'b1;
        if (host_wr && (host_addr == A_SIG)) r_d.sig = host_wdata;
        if (host_rd) r_d.hrd = word_at(host_addr, r_q.cmd, r_q.sig, args, lock_grant);
        if (dev_rd)  r_d.drd = word_at(dev_addr, r_q.cmd, r_q.sig, args, lock_held);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= MB_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_word   = r_q.cmd;
    assign host_rdata = r_q.hrd;
    assign dev_rdata  = r_q.drd;
    assign stuck_irq  = r_q.irq;
    assign cmd_error  = r_q.err;
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       cmd_word,
    input logic              lock_held,
    input logic              sig_valid,
    input logic              stuck_irq,
    input logic              cmd_error,
    input logic              dev_wr,
    input logic [ADDR_W-1:0] dev_addr
);
    // R5: a command only appears under lock with a valid identity word
    a_r5_cmd_under_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_word[31]) |-> ($past(lock_held) && $past(sig_valid)));

    // R4: identity check feeds acceptance
    a_r4_cmd_needs_id: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_word[31] && !$past(cmd_word[31])) |-> $past(sig_valid));

    // R6: an answer needs a device write to the command word
    a_r6_rsp_from_device: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cmd_word[31]) && (cmd_word != '0) && !stuck_irq)
        |-> $past(dev_wr && (dev_addr == '0)));

    // R8: interrupt is a single pulse
    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_irq |=> !stuck_irq);

    // R8: reclaim frees the lock and leaves the timeout code
    a_r8_irq_reclaims: assert property (@(posedge clk) disable iff (!rst_n)
        stuck_irq |-> (!lock_held && (cmd_word == 32'h3)));

    // R9: error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |=> cmd_error);
endmodule

bind host_mbox_unit mbox_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .lock_held(lock_held),
    .sig_valid(sig_valid), .stuck_irq(stuck_irq), .cmd_error(cmd_error),
    .dev_wr(dev_wr), .dev_addr(dev_addr)
);

// File: tb/host_mbox_unit_tb.sv
module host_mbox_unit_tb;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned TMO_W  = 16;
    localparam logic [2:0] A_CMD = 3'd0, A_A1 = 3'd1, A_A2 = 3'd2, A_A3 = 3'd3;
    localparam logic [2:0] A_SIG = 3'd4, A_LOCK = 3'd5;
    localparam logic [31:0] GOOD_ID = 32'hCAFE_0103;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_wr = 0, host_rd = 0, dev_wr = 0, dev_rd = 0;
    logic [ADDR_W-1:0] host_addr = '0, dev_addr = '0;
    logic [31:0] host_wdata = '0, dev_wdata = '0;
    logic [31:0] host_rdata, dev_rdata;
    logic [TMO_W-1:0] stuck_limit = '0;
    logic stuck_irq, cmd_error;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    host_mbox_unit #(.N_ARGS(3), .ADDR_W(ADDR_W), .TMO_W(TMO_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_addr(dev_addr),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .stuck_limit(stuck_limit), .stuck_irq(stuck_irq), .cmd_error(cmd_error)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic h_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic h_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1; host_addr = a;
        @(negedge clk);
        host_rd = 0;
        d = host_rdata;
    endtask

    task automatic d_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        dev_wr = 1; dev_addr = a; dev_wdata = d;
        @(negedge clk);
        dev_wr = 0;
    endtask

    task automatic d_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        dev_rd = 1; dev_addr = a;
        @(negedge clk);
        dev_rd = 0;
        d = dev_rdata;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        for (int a = 0; a < 5; a++) begin
            d_read(3'(a), v);
            chk("R1 word after reset", v, 32'h0);
        end
        d_read(A_LOCK, v);
        chk("R1 lock free after reset", v, 32'h0);
        chk("R1 irq after reset", {31'b0, stuck_irq}, 32'h0);
        chk("R1 error after reset", {31'b0, cmd_error}, 32'h0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        do_reset();
        h_read(A_LOCK, v);
        chk("R2 first take returns 1", v, 32'h1);
        d_read(A_LOCK, v);
        chk("R2 device sees held", v, 32'h1);
        h_read(A_LOCK, v);
        chk("R2 second take returns 0", v, 32'h0);
        h_write(A_LOCK, 32'h0);
        d_read(A_LOCK, v);
        chk("R2 released", v, 32'h0);
        h_read(A_LOCK, v);
        chk("R2 retake after release", v, 32'h1);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        do_reset();
        h_write(A_A1, 32'h1111_0001);
        h_write(A_A2, 32'h2222_0002);
        h_write(A_A3, 32'h3333_0003);
        h_write(A_SIG, GOOD_ID);
        d_read(A_A1, v);  chk("R3 arg1 host->device", v, 32'h1111_0001);
        d_read(A_A3, v);  chk("R3 arg3 host->device", v, 32'h3333_0003);
        d_write(A_A2, 32'hDEAD_0022);
        h_read(A_A2, v);  chk("R3 arg2 device->host", v, 32'hDEAD_0022);
        d_write(A_SIG, 32'h1234_5678);
        h_read(A_SIG, v); chk("R3 device cannot write id", v, GOOD_ID);
        @(negedge clk);
        host_wr = 1; host_addr = A_A1; host_wdata = 32'hAAAA_AAAA;
        dev_wr  = 1; dev_addr  = A_A1; dev_wdata  = 32'h5555_5555;
        @(negedge clk);
        host_wr = 0; dev_wr = 0;
        d_read(A_A1, v);  chk("R3 host priority on collision", v, 32'hAAAA_AAAA);
    endtask

    task automatic t_cmd_rules();
        logic [31:0] v;
        do_reset();
        h_write(A_SIG, GOOD_ID);
        h_write(A_CMD, 32'h8000_0001);
        d_read(A_CMD, v);  chk("R5 rejected without lock", v, 32'h0);
        chk("R5 error set", {31'b0, cmd_error}, 32'h1);
        h_read(A_LOCK, v);
        h_write(A_SIG, 32'hCAFE_0108);
        h_write(A_CMD, 32'h8000_0001);
        d_read(A_CMD, v);  chk("R4 function 8 rejected", v, 32'h0);
        h_write(A_SIG, 32'hCAFF_0101);
        h_write(A_CMD, 32'h8000_0001);
        d_read(A_CMD, v);  chk("R4 wrong magic rejected", v, 32'h0);
        h_write(A_SIG, 32'hCAFE_FF07);
        h_write(A_CMD, 32'h8000_000C);
        d_read(A_CMD, v);  chk("R5 code in hole rejected", v, 32'h0);
        h_write(A_CMD, 32'h8000_0013);
        d_read(A_CMD, v);  chk("R5 code past range rejected", v, 32'h0);
        h_write(A_CMD, 32'h0000_0001);
        d_read(A_CMD, v);  chk("R5 host code without bit31 rejected", v, 32'h0);
        h_write(A_CMD, 32'h8000_0012);
        d_read(A_CMD, v);  chk("R4 R5 last code accepted, version free", v, 32'h8000_0012);
        h_write(A_CMD, 32'h8000_0001);
        d_read(A_CMD, v);  chk("R5 busy mailbox keeps command", v, 32'h8000_0012);
    endtask

    task automatic t_response();
        logic [31:0] v;
        do_reset();
        h_write(A_SIG, GOOD_ID);
        h_read(A_LOCK, v);
        d_write(A_CMD, 32'h0000_0001);
        h_read(A_CMD, v);  chk("R6 answer without command ignored", v, 32'h0);
        h_write(A_CMD, 32'h8000_0002);
        d_write(A_CMD, 32'h8000_0005);
        h_read(A_CMD, v);  chk("R6 device bit31 ignored", v, 32'h8000_0002);
        d_write(A_CMD, 32'h0000_0001);
        h_read(A_CMD, v);  chk("R6 response accepted", v, 32'h0000_0001);
        d_write(A_CMD, 32'h0000_0002);
        h_read(A_CMD, v);  chk("R6 second response ignored", v, 32'h0000_0001);
        h_write(A_CMD, 32'h0);
        h_read(A_CMD, v);  chk("R7 clear", v, 32'h0);
        chk("R7 clear raises no error", {31'b0, cmd_error}, 32'h0);
        h_write(A_CMD, 32'h8000_0007);
        h_read(A_CMD, v);  chk("R7 re-armed", v, 32'h8000_0007);
        h_write(A_CMD, 32'h0);
        h_write(A_LOCK, 32'h0);
        h_write(A_CMD, 32'h8000_0003);
        chk("R9 error set by reject", {31'b0, cmd_error}, 32'h1);
        h_read(A_LOCK, v);
        h_write(A_CMD, 32'h8000_0003);
        d_write(A_CMD, 32'h0000_0002);
        h_write(A_CMD, 32'h0);
        chk("R9 error stays after good transaction", {31'b0, cmd_error}, 32'h1);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        do_reset();
        stuck_limit = 16'd10;
        h_write(A_SIG, GOOD_ID);
        h_read(A_LOCK, v);
        h_write(A_CMD, 32'h8000_0007);
        repeat (9) @(negedge clk);
        chk("R8 no irq before limit", {31'b0, stuck_irq}, 32'h0);
        @(negedge clk);
        chk("R8 irq at limit", {31'b0, stuck_irq}, 32'h1);
        @(negedge clk);
        chk("R8 irq single cycle", {31'b0, stuck_irq}, 32'h0);
        d_read(A_CMD, v);  chk("R8 timeout code", v, 32'h3);
        d_read(A_LOCK, v); chk("R8 lock freed", v, 32'h0);
        d_write(A_CMD, 32'h0000_0001);
        d_read(A_CMD, v);  chk("R6 no answer after timeout", v, 32'h3);
        h_write(A_CMD, 32'h0);
        h_read(A_LOCK, v); chk("R8 lock retakeable", v, 32'h1);
        h_write(A_CMD, 32'h8000_0001);
        repeat (5) @(negedge clk);
        d_write(A_CMD, 32'h0000_0001);
        repeat (8) @(negedge clk);
        chk("R8 answer restarts window", {31'b0, stuck_irq}, 32'h0);
        d_read(A_CMD, v);  chk("R8 answer kept inside window", v, 32'h1);
        stuck_limit = 16'd0;
    endtask

    task automatic t_no_limit();
        logic [31:0] v;
        logic seen;
        do_reset();
        stuck_limit = 16'd0;
        h_write(A_SIG, GOOD_ID);
        h_read(A_LOCK, v);
        h_write(A_CMD, 32'h8000_0011);
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (stuck_irq) seen = 1'b1;
        end
        chk("R8 limit 0 never fires", {31'b0, seen}, 32'h0);
        d_read(A_CMD, v); chk("R8 limit 0 keeps command", v, 32'h8000_0011);
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_lock();
        t_regs();
        t_cmd_rules();
        t_response();
        t_timeout();
        t_no_limit();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule